// File: doc/BRIEF.md
# Register Access Key Sequencer

This block decides whether a set of special register and memory windows is reachable. Software opens the windows by writing a fixed pair of 32-bit magic words, one after the other, to a key register. The block turns those writes into a single registered `unlocked` flag. That flag drives the register-access enable of the address decoder, which lies outside this block.

The key register accepts writes whether the block is locked or unlocked. Three write values have fixed meanings:

- A write of zero abandons any partial sequence.
- A write of all-ones relocks an open block.
- The first magic word (0x5F55_4E4C) followed by the second (0x4F43_4B5F) as the very next key write opens a locked block.

Either the power-on reset or the console soft reset forces the lock closed. Each reset also clears any partial sequence.

Top module: `key_seq_gate`

## Requirements
- R1: After `rst` or `soft_rst` is sampled high at a rising edge, `unlocked` is 0 from that edge on, and any partial sequence is cleared. A reset wins over a key write in the same cycle.
- R2: While locked, a key write of 0x5F55_4E4C followed by a key write of 0x4F43_4B5F as the next key write sets `unlocked` to 1. The flag is seen at the edge that samples the second write, so it is visible during the following cycle.
- R3: Cycles with `key_wr` low change nothing, whatever `key_data` holds. Idle cycles between the two magic words do not break the sequence.
- R4: A key write of 0x0000_0000 returns the sequencer to its initial step. For example, the writes first word, zero, second word leave the block locked.
- R5: After the first word, any key write other than the second word returns the sequencer to its initial step. That write is then evaluated as a possible first word, so first, first, second unlocks, while first, other, second does not.
- R6: A key write of 0xFFFF_FFFF while unlocked clears `unlocked` at the edge that samples it. The same write while locked leaves the block locked.
- R7: While unlocked, any key write other than 0xFFFF_FFFF, including zero and either magic word, leaves `unlocked` at 1.
- R8: The second magic word alone never unlocks. No partial sequence survives an unlocked period, so after a relock the full pair is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| soft_rst | input | 1 | Console soft reset, synchronous, active high |
| key_wr | input | 1 | Key register write strobe |
| key_data | input | 32 | Key register write data |
| unlocked | output | 1 | Registered access-enable flag for the decoder |

## Verification
A console soft reset and the write that completes the unlock sequence can arrive in the same cycle. In that case the reset must win and the flag must stay low. The bench provokes this collision by arming the sequencer with the first word and then presenting the second word with `soft_rst` high in the same cycle. It then confirms that `unlocked` is still 0 afterwards. It also confirms that a later lone second word does not open the block, which shows the armed step was cleared as well.

// File: rtl/key_seq_pkg.sv
package key_seq_pkg;
  parameter int KEY_W = 32;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 32'h5F55_4E4C;
  localparam logic [KEY_W-1:0] KEY_SECOND = 32'h4F43_4B5F;
  localparam logic [KEY_W-1:0] KEY_CLEAR  = '0;
  localparam logic [KEY_W-1:0] KEY_RELOCK = '1;

  typedef enum logic [2:0] {
    KC_OTHER,
    KC_FIRST,
    KC_SECOND,
    KC_CLEAR,
    KC_RELOCK
  } key_class_t;
endpackage

// File: rtl/key_classify.sv
module key_classify
  import key_seq_pkg::*;
#(
  parameter int W = KEY_W
) (
  input  logic [W-1:0] data,
  output key_class_t   kclass
);
  always_comb begin
    if (data == KEY_FIRST)       kclass = KC_FIRST;
    else if (data == KEY_SECOND) kclass = KC_SECOND;
    else if (data == KEY_CLEAR)  kclass = KC_CLEAR;
    else if (data == KEY_RELOCK) kclass = KC_RELOCK;
    else                         kclass = KC_OTHER;
  end
endmodule

// File: rtl/key_fsm.sv
module key_fsm
  import key_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       wr,
  input  key_class_t kclass,
  output logic       unlocked
);
  logic armed_q;
  logic open_q;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr) begin
      if (open_q) begin
        armed_q <= 1'b0;
        if (kclass == KC_RELOCK) open_q <= 1'b0;
      end else if (armed_q && kclass == KC_SECOND) begin
        open_q  <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        armed_q <= (kclass == KC_FIRST);
      end
    end
  end

  assign unlocked = open_q;

  AST_RESET_LOCKS: assert property (@(posedge clk) (rst || soft_rst) |=> !open_q); // R1
  AST_OPEN_NEEDS_SECOND: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(wr && kclass == KC_SECOND && armed_q)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr && !soft_rst) |=> $stable(open_q)); // R3
  AST_RELOCK: assert property (@(posedge clk) disable iff (rst)
    (open_q && wr && kclass == KC_RELOCK && !soft_rst) |=> !open_q); // R6
  AST_STAY_OPEN: assert property (@(posedge clk) disable iff (rst)
    (open_q && wr && kclass != KC_RELOCK && !soft_rst) |=> open_q); // R7
  AST_NO_ARM_WHILE_OPEN: assert property (@(posedge clk) disable iff (rst)
    (open_q && !soft_rst) |=> !armed_q); // R8
endmodule

// File: rtl/key_seq_gate.sv
module key_seq_gate
  import key_seq_pkg::*;
#(
  parameter int W = KEY_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         key_wr,
  input  logic [W-1:0] key_data,
  output logic         unlocked
);
  key_class_t kclass;

  key_classify #(.W(W)) classify_i (
    .data   (key_data),
    .kclass (kclass)
  );

  key_fsm fsm_i (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .wr       (key_wr),
    .kclass   (kclass),
    .unlocked (unlocked)
  );
endmodule

// File: tb/key_seq_gate_tb_top.sv
module key_seq_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] W1 = 32'h5F55_4E4C;
  localparam logic [31:0] W2 = 32'h4F43_4B5F;
  localparam logic [31:0] Z  = 32'h0000_0000;
  localparam logic [31:0] F  = 32'hFFFF_FFFF;
  localparam int NV = 23;

  // {wr, data, expected unlocked, requirement number}
  typedef struct packed {
    logic        wr;
    logic [31:0] data;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, W1, 1'b0, 4'd2},            // R2 first word
    '{1'b1, W2, 1'b1, 4'd2},            // R2 unlock
    '{1'b1, W1, 1'b1, 4'd7},            // R7
    '{1'b1, Z,  1'b1, 4'd7},            // R7
    '{1'b0, F,  1'b1, 4'd3},            // R3 idle with ones on bus
    '{1'b1, F,  1'b0, 4'd6},            // R6 relock
    '{1'b1, W2, 1'b0, 4'd8},            // R8 lone second word
    '{1'b1, W1, 1'b0, 4'd3},
    '{1'b0, W2, 1'b0, 4'd3},            // R3 idle gap
    '{1'b1, W2, 1'b1, 4'd3},            // R3 unlock across gap
    '{1'b1, F,  1'b0, 4'd6},
    '{1'b1, W1, 1'b0, 4'd4},
    '{1'b1, Z,  1'b0, 4'd4},            // R4 zero clears
    '{1'b1, W2, 1'b0, 4'd4},
    '{1'b1, W1, 1'b0, 4'd5},
    '{1'b1, 32'h1234_5678, 1'b0, 4'd5}, // R5 other word
    '{1'b1, W2, 1'b0, 4'd5},
    '{1'b1, W1, 1'b0, 4'd5},
    '{1'b1, W1, 1'b0, 4'd5},            // R5 re-evaluated as first
    '{1'b1, W2, 1'b1, 4'd5},
    '{1'b1, F,  1'b0, 4'd6},
    '{1'b1, F,  1'b0, 4'd6},            // R6 ones while locked
    '{1'b1, W2, 1'b0, 4'd8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 1'b0;
  logic key_wr = 1'b0;
  logic [31:0] key_data = '0;
  logic unlocked;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_seq_gate dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .key_wr(key_wr), .key_data(key_data), .unlocked(unlocked)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if (unlocked !== exp) begin
      errors++;
      $display("FAIL %s unlocked=%0b expected=%0b", tag, unlocked, exp);
    end
  endtask

  // Drive one key write at a negedge, then sample at the next negedge.
  task automatic wr_key(input logic [31:0] d);
    key_wr = 1'b1; key_data = d;
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 power-on reset", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset release", 1'b0);

    for (int i = 0; i < NV; i++) begin
      key_wr = VECS[i].wr; key_data = VECS[i].data;
      @(negedge clk);
      checks++;
      if (unlocked !== VECS[i].exp) begin
        errors++;
        $display("FAIL R%0d row %0d unlocked=%0b expected=%0b",
                 VECS[i].req, i, unlocked, VECS[i].exp);
      end
    end
    key_wr = 1'b0;

    // R1: soft reset while unlocked
    wr_key(W1); wr_key(W2);
    check("R2 unlock before soft reset", 1'b1);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    check("R1 soft reset locks", 1'b0);

    // R1: soft reset collides with the completing write
    wr_key(W1);
    soft_rst = 1'b1; key_wr = 1'b1; key_data = W2;
    @(negedge clk);
    soft_rst = 1'b0; key_wr = 1'b0;
    check("R1 reset beats completing write", 1'b0);
    wr_key(W2);
    check("R1 armed step cleared by reset", 1'b0);

    // R1: power-on reset while unlocked, with a write in the same cycle
    wr_key(W1); wr_key(W2);
    check("R2 unlock before power-on reset", 1'b1);
    rst = 1'b1; key_wr = 1'b1; key_data = W1;
    @(negedge clk);
    rst = 1'b0; key_wr = 1'b0;
    check("R1 power-on reset locks", 1'b0);

    // R8: first word given while unlocked does not survive relock
    wr_key(W1); wr_key(W2);
    wr_key(W1); wr_key(F);
    check("R6 relock", 1'b0);
    wr_key(W2);
    check("R8 no arming across unlocked period", 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule